// File: doc/BRIEF.md
# Dual-Pointer Auto-Stepping Memory Port

This block sits between an 8-bit host register bus and a 17-bit byte-addressed video memory. It keeps two independent address pointers. Each pointer has its own 4-bit stride code and its own direction flag. When the host reads or writes a pointer's data register, the block accesses memory at that pointer's current address. It then moves the pointer by the coded stride, forward or backward. Software can therefore stream through tables, columns or whole rows without reloading the address each time.

A single set of three address registers shows whichever pointer the control register selects. The control register also holds a bank bit for a secondary register window, which is driven out on a pin. It also has a self-clearing bit that returns the block to its power-on state. Register offsets 9 to 12 belong to that secondary window and are not implemented here; they read as zero. The memory itself is outside the block. It is a synchronous array with a one-cycle read latency. Every host read answers one cycle after its strobe, with `host_rvalid` high.

Top module: `vmem_window_port`

## Requirements
- R1: After `rst_n` is released, offsets 0, 1, 2 and 5 all read 0x00 for either pointer, and `aux_bank` is 0.
- R2: Offset 0 holds pointer bits 7:0 and offset 1 holds bits 15:8. Offset 2 holds bit 16 in bit 0, the direction flag in bit 3 and the stride code in bits 7:4. Bits 2:1 of offset 2 always read 0.
- R3: Control (offset 5) bit 0 selects which pointer offsets 0 to 2 read and write. The other pointer's address, code and flag stay unchanged.
- R4: A read of offset 3 (port 0) or offset 4 (port 1) returns the memory byte at that port's address before the step. The byte appears on `host_rdata` one cycle after the strobe, and `host_rvalid` is high in that cycle. Register reads use the same timing.
- R5: A write of offset 3 or 4 stores `host_wdata` at that port's pre-step address. The updated address is then visible through offsets 0 to 2.
- R6: Stride codes 0 to 15 map to strides 0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 40, 80, 160, 320 and 640.
- R7: With the direction flag at 0, an access adds the stride to the pointer. With the flag at 1, it subtracts the stride.
- R8: Pointer arithmetic wraps modulo 2^17. For example, 0x1FFFF plus 1 gives 0x00000, and 0x00000 minus 640 gives 0x1FD80.
- R9: With stride code 0, a data-port access leaves the pointer unchanged.
- R10: Control bit 1 drives `aux_bank` and reads back in bit 1 of offset 5. Offsets 9 to 12, and every unmapped offset, read 0x00. Writes to those offsets change no readable state.
- R11: Writing control with bit 7 set clears both pointers, both codes, both flags, the select bit and the bank bit. Bit 7 always reads 0.
- R12: An access to one data port never changes the other port's pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | High one cycle after a read strobe |
| mem_addr | output | 17 | Memory byte address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| aux_bank | output | 1 | Secondary window bank select |

## Verification
The bench uses the block's fixed 17-bit pointer width and 4-bit offset bus. The whole stride table and both wrap points can therefore be reached with directed accesses. Thousands of random accesses follow, with a fixed seed. They mix pointer selection, direction changes and accesses to both ports. This covers the cases where one pointer is reprogrammed while the other keeps streaming. The bench memory folds the upper address bits into its index. Addresses near both ends of the 17-bit space therefore land on distinct entries.

// File: rtl/vmem_window_port.sv
module vmem_window_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_cs,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_rvalid,
  output logic [16:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        aux_bank
);

  localparam logic [3:0] OFS_LO   = 4'd0;
  localparam logic [3:0] OFS_MID  = 4'd1;
  localparam logic [3:0] OFS_HI   = 4'd2;
  localparam logic [3:0] OFS_DP0  = 4'd3;
  localparam logic [3:0] OFS_DP1  = 4'd4;
  localparam logic [3:0] OFS_CTRL = 4'd5;

  logic [16:0] ptr_q  [2];
  logic [3:0]  code_q [2];
  logic        dec_q  [2];
  logic        sel_q, bank_q;
  logic        rsp_mem_q, rvalid_q;
  logic [7:0]  rsp_reg_q, reg_rdata;

  function automatic logic [16:0] stride(input logic [3:0] c);
    case (c)
      4'd0:    stride = 17'd0;
      4'd11:   stride = 17'd40;
      4'd12:   stride = 17'd80;
      4'd13:   stride = 17'd160;
      4'd14:   stride = 17'd320;
      4'd15:   stride = 17'd640;
      default: stride = 17'd1 << (c - 4'd1);
    endcase
  endfunction

  wire is_dp    = host_cs && (host_addr == OFS_DP0 || host_addr == OFS_DP1);
  wire dp       = (host_addr == OFS_DP1);
  wire soft_rst = host_cs && host_wr && host_addr == OFS_CTRL && host_wdata[7];
  wire [16:0] step = stride(code_q[dp]);
  wire [16:0] ptr_next = dec_q[dp] ? ptr_q[dp] - step : ptr_q[dp] + step;

  assign mem_addr  = ptr_q[dp];
  assign mem_we    = is_dp && host_wr;
  assign mem_re    = is_dp && !host_wr;
  assign mem_wdata = host_wdata;
  assign aux_bank  = bank_q;

  always_comb begin
    case (host_addr)
      OFS_LO:   reg_rdata = ptr_q[sel_q][7:0];
      OFS_MID:  reg_rdata = ptr_q[sel_q][15:8];
      OFS_HI:   reg_rdata = {code_q[sel_q], dec_q[sel_q], 2'b00, ptr_q[sel_q][16]};
      OFS_CTRL: reg_rdata = {6'd0, bank_q, sel_q};
      default:  reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ptr_q[i]  <= '0;
        code_q[i] <= '0;
        dec_q[i]  <= 1'b0;
      end
      sel_q  <= 1'b0;
      bank_q <= 1'b0;
    end else if (soft_rst) begin
      for (int i = 0; i < 2; i++) begin
        ptr_q[i]  <= '0;
        code_q[i] <= '0;
        dec_q[i]  <= 1'b0;
      end
      sel_q  <= 1'b0;
      bank_q <= 1'b0;
    end else if (is_dp) begin
      ptr_q[dp] <= ptr_next;
    end else if (host_cs && host_wr) begin
      case (host_addr)
        OFS_LO:   ptr_q[sel_q][7:0]  <= host_wdata;
        OFS_MID:  ptr_q[sel_q][15:8] <= host_wdata;
        OFS_HI: begin
          ptr_q[sel_q][16] <= host_wdata[0];
          dec_q[sel_q]     <= host_wdata[3];
          code_q[sel_q]    <= host_wdata[7:4];
        end
        OFS_CTRL: begin
          sel_q  <= host_wdata[0];
          bank_q <= host_wdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q  <= 1'b0;
      rsp_mem_q <= 1'b0;
      rsp_reg_q <= '0;
    end else begin
      rvalid_q  <= host_cs && !host_wr;
      rsp_mem_q <= mem_re;
      rsp_reg_q <= reg_rdata;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rsp_mem_q ? mem_rdata : rsp_reg_q;

endmodule

// File: rtl/vmem_window_port_chk.sv
module vmem_window_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_cs,
  input logic        host_wr,
  input logic [3:0]  host_addr,
  input logic        wbit7,
  input logic        host_rvalid,
  input logic [16:0] mem_addr,
  input logic        mem_we,
  input logic [16:0] ptr0,
  input logic [16:0] ptr1,
  input logic [3:0]  code0,
  input logic        sel,
  input logic        bank
);

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && !host_wr) |=> host_rvalid); // R4

  AST_PORT0_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_wr && host_addr == 4'd3) |-> (mem_we && mem_addr == ptr0)); // R5

  AST_PORT1_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_addr == 4'd4) |-> (mem_addr == ptr1)); // R4

  AST_ZERO_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_addr == 4'd3 && code0 == 4'd0) |=> $stable(ptr0)); // R9

  AST_OTHER_PORT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_addr == 4'd4) |=> $stable(ptr0)); // R12

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_wr && host_addr == 4'd5 && wbit7) |=>
      (ptr0 == 17'd0 && ptr1 == 17'd0 && !sel && !bank)); // R11

endmodule

bind vmem_window_port vmem_window_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
  .host_addr(host_addr), .wbit7(host_wdata[7]), .host_rvalid(host_rvalid),
  .mem_addr(mem_addr), .mem_we(mem_we), .ptr0(ptr_q[0]), .ptr1(ptr_q[1]),
  .code0(code_q[0]), .sel(sel_q), .bank(bank_q)
);

// File: tb/vmem_window_port_bench.sv
module vmem_window_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs = 1'b0, host_wr = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata, mem_wdata, mem_rdata;
  logic        host_rvalid, mem_we, mem_re, aux_bank;
  logic [16:0] mem_addr;

  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  vmem_window_port u_vmem_window_port (
    .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .aux_bank(aux_bank)
  );

  logic [7:0] ram [4096];
  logic [7:0] shadow [4096];

  function automatic int fold(input logic [16:0] a);
    return int'(a[11:0] ^ {7'd0, a[16:12]});
  endfunction

  always @(posedge clk) begin
    if (mem_we) ram[fold(mem_addr)] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[fold(mem_addr)];
  end

  logic [16:0] m_ptr [2];
  logic [3:0]  m_code [2];
  logic        m_dec [2];
  logic        m_sel, m_bank;

  function automatic logic [16:0] exp_stride(input logic [3:0] c);
    int t [16] = '{0, 1, 2, 4, 8, 16, 32, 64, 128, 256, 512, 40, 80, 160, 320, 640};
    return 17'(t[c]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      m_ptr[i] = '0; m_code[i] = '0; m_dec[i] = 1'b0;
    end
    m_sel = 1'b0; m_bank = 1'b0;
  endtask

  task automatic model_step(input int p);
    if (m_dec[p]) m_ptr[p] = m_ptr[p] - exp_stride(m_code[p]);
    else          m_ptr[p] = m_ptr[p] + exp_stride(m_code[p]);
  endtask

  task automatic wr(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b1; host_addr = off; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_wr = 1'b0;
    case (off)
      4'd0: m_ptr[m_sel][7:0] = d;
      4'd1: m_ptr[m_sel][15:8] = d;
      4'd2: begin m_ptr[m_sel][16] = d[0]; m_dec[m_sel] = d[3]; m_code[m_sel] = d[7:4]; end
      4'd3, 4'd4: begin
        shadow[fold(m_ptr[off - 4'd3])] = d;
        model_step(int'(off) - 3);
      end
      4'd5: if (d[7]) model_clear(); else begin m_sel = d[0]; m_bank = d[1]; end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] off, input string req);
    logic [7:0] e;
    @(negedge clk);
    host_cs = 1'b1; host_wr = 1'b0; host_addr = off;
    case (off)
      4'd0: e = m_ptr[m_sel][7:0];
      4'd1: e = m_ptr[m_sel][15:8];
      4'd2: e = {m_code[m_sel], m_dec[m_sel], 2'b00, m_ptr[m_sel][16]};
      4'd3, 4'd4: begin
        e = shadow[fold(m_ptr[off - 4'd3])];
        model_step(int'(off) - 3);
      end
      4'd5: e = {6'd0, m_bank, m_sel};
      default: e = 8'd0;
    endcase
    @(negedge clk);
    host_cs = 1'b0;
    check({req, " rvalid"}, int'(host_rvalid), 1);
    check(req, int'(host_rdata), int'(e));
  endtask

  task automatic set_ptr(input logic [16:0] a, input logic [3:0] c, input logic d);
    wr(4'd0, a[7:0]);
    wr(4'd1, a[15:8]);
    wr(4'd2, {c, d, 2'b00, a[16]});
  endtask

  task automatic read_ptr(input string req);
    rd(4'd0, req); rd(4'd1, req); rd(4'd2, req);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin ram[i] = 8'd0; shadow[i] = 8'd0; end
    model_clear();
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_ptr("R1"); rd(4'd5, "R1");
    check("R1 aux_bank", int'(aux_bank), 0);
    wr(4'd5, 8'h01); read_ptr("R1"); wr(4'd5, 8'h00);

    // R2 field layout, gap bits read zero
    set_ptr(17'h1A5C3, 4'h7, 1'b1);
    wr(4'd2, 8'hFF);
    read_ptr("R2");

    // R3 independent pointers through select
    wr(4'd5, 8'h01); set_ptr(17'h0BEEF, 4'h2, 1'b0);
    wr(4'd5, 8'h00); read_ptr("R3");
    wr(4'd5, 8'h01); read_ptr("R3");

    // R6 whole stride table on port 1, R4/R5 write-then-read
    for (int c = 0; c < 16; c++) begin
      wr(4'd5, 8'h01);
      set_ptr(17'h04000, 4'(c), 1'b0);
      wr(4'd4, 8'(c + 8'h30));
      read_ptr("R6");
      set_ptr(17'h04000, 4'd0, 1'b0);
      rd(4'd4, "R5");
    end

    // R7 decrement, R8 wrap both ways
    wr(4'd5, 8'h00);
    set_ptr(17'h00500, 4'd12, 1'b1);
    rd(4'd3, "R7"); read_ptr("R7");
    set_ptr(17'h1FFFF, 4'd1, 1'b0);
    wr(4'd3, 8'hA7); read_ptr("R8");
    set_ptr(17'h00000, 4'd15, 1'b1);
    wr(4'd3, 8'h5A); read_ptr("R8");
    check("R8 wrap address", int'(m_ptr[0]), 32'h1FD80);

    // R9 zero code keeps pointer, R12 other port untouched
    set_ptr(17'h12345, 4'd0, 1'b0);
    rd(4'd3, "R9"); rd(4'd3, "R9"); read_ptr("R9");
    wr(4'd5, 8'h01); set_ptr(17'h00100, 4'd13, 1'b0);
    wr(4'd4, 8'h11); wr(4'd4, 8'h22);
    wr(4'd5, 8'h00); read_ptr("R12");

    // R10 bank bit and secondary window
    wr(4'd5, 8'h02);
    check("R10 aux_bank", int'(aux_bank), 1);
    rd(4'd5, "R10");
    for (int o = 6; o < 16; o++) begin
      wr(4'(o), 8'hFF);
      rd(4'(o), "R10");
    end
    read_ptr("R10");

    // R11 soft reset
    wr(4'd5, 8'h83);
    check("R11 aux_bank", int'(aux_bank), 0);
    rd(4'd5, "R11"); read_ptr("R11");
    wr(4'd5, 8'h01); read_ptr("R11");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      logic [3:0] off;
      logic [7:0] d = 8'($urandom);
      if (r < 12)      off = 4'd0;
      else if (r < 20) off = 4'd1;
      else if (r < 32) off = 4'd2;
      else if (r < 56) off = 4'd3;
      else if (r < 80) off = 4'd4;
      else if (r < 92) off = 4'd5;
      else             off = 4'($urandom_range(6, 15));
      if (off == 4'd5 && $urandom_range(0, 15) != 0) d[7] = 1'b0;
      if ($urandom_range(0, 1) == 1) wr(off, d);
      else rd(off, (off == 4'd3 || off == 4'd4) ? "R4" : "R3");
    end

    finish_run();
  end

endmodule